// File: doc/BRIEF.md
# Packed Even-Lane Widening Multiplier

This block is a pipelined SIMD execution unit. It multiplies unsigned 32-bit elements and returns products twice as wide. Each 128-bit operand holds four doublewords. Only the even ones take part: doubleword 0 occupies bits [31:0] and doubleword 2 occupies bits [95:64]. Each product fills a full 64-bit result lane. The odd doublewords of both operands have no effect on the result.

A per-operation mode bit sets how many lanes are active. In narrow mode, one product is formed from the low doublewords and the upper half of the result is zero. In wide mode, two products are formed, one per 64-bit lane. The unit accepts a new operation on every clock. Each result appears a fixed, parameterised number of cycles later. The issuing logic tracks the result from the output valid strobe alone. There are no flags and no stall path.

Top module: `evenLaneMul`

## Requirements
- R1: In both modes, result bits [63:0] equal the 64-bit unsigned product of destination bits [31:0] and source bits [31:0].
- R2: When the mode input `inWide` is 1, result bits [127:64] equal the unsigned product of destination bits [95:64] and source bits [95:64].
- R3: When `inWide` is 0, result bits [127:64] are all zero.
- R4: Operand bits [63:32] and [127:96] of both operands have no effect on the result.
- R5: Both multiplicands are unsigned. All-ones times all-ones gives 64'hFFFF_FFFE_0000_0001. 32'h8000_0000 times 2 gives 64'h0000_0001_0000_0000.
- R6: `outValid` is high in exactly the cycles that follow an `inValid`-high cycle by `LATENCY` clock edges (default 6), and low in all other cycles.
- R7: A new operation, with its own mode, is accepted on every cycle. Back-to-back operations with differing modes each produce their own correct result.
- R8: A synchronous active-high `rst` drops every operation in flight and any operation presented in the same cycle. `outValid` is low in the cycle after `rst` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the pipeline valids |
| inValid | input | 1 | Operation presented this cycle |
| inWide | input | 1 | 1 = two lanes (wide), 0 = low lane only (narrow) |
| dstOp | input | 128 | First operand, even doublewords used |
| srcOp | input | 128 | Second operand, even doublewords used |
| outValid | output | 1 | Result valid, `LATENCY` cycles after `inValid` |
| outResult | output | 128 | Two 64-bit product lanes |

## Verification
Two things can meet in one cycle: a change of mode between neighbouring operations, and the masking of the upper lane. A narrow operation that directly follows a wide one must not inherit the previous upper product. The same holds when a reset strikes while both kinds are in flight. The random stream picks the mode and the valid bit for each cycle independently, and the odd doublewords always carry random data. A mid-stream reset is also applied in the same cycle as a fresh operation. Each output cycle is judged against a ring of expected values indexed by issue cycle. A stale upper lane, a misplaced valid, or a result that survives the reset shows up as a mismatch.

// File: rtl/evenMulPkg.sv
package evenMulPkg;

  // Pipeline depth consumed by capture, partial products and lane sum
  localparam int MIN_LATENCY = 3;

  // Strobes from control to datapath, one per loaded stage
  typedef struct packed {
    logic capEn;      // operand capture stage loads
    logic ppEn;       // partial-product stage loads
    logic sumEn;      // lane-sum stage loads
    logic wideAtSum;  // mode of the operation entering the sum stage
  } mulStrobes_t;

endpackage

// File: rtl/evenMulCtrl.sv
module evenMulCtrl
  import evenMulPkg::*;
#(
  parameter int LATENCY = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inWide,
  output mulStrobes_t strobes,
  output logic        outValid
);

  // vldPipe[k] marks an operation that has passed k clock edges
  logic [LATENCY:1] vldPipe;
  logic             wideS1;
  logic             wideS2;

  always_ff @(posedge clk) begin
    if (rst) begin
      vldPipe <= '0;
    end else begin
      vldPipe <= {vldPipe[LATENCY-1:1], inValid};
    end
  end

  // Mode follows its operation through the stages that still need it
  always_ff @(posedge clk) begin
    if (inValid) wideS1 <= inWide;
    if (vldPipe[1]) wideS2 <= wideS1;
  end

  always_comb begin
    strobes.capEn     = inValid;
    strobes.ppEn      = vldPipe[1];
    strobes.sumEn     = vldPipe[2];
    strobes.wideAtSum = wideS2;
  end

  assign outValid = vldPipe[LATENCY];

endmodule

// File: rtl/evenMulDatapath.sv
module evenMulDatapath
  import evenMulPkg::*;
#(
  parameter int ELEM_W   = 32,
  parameter int LANE_CNT = 2,
  parameter int LATENCY  = 6,
  localparam int QW      = 2 * ELEM_W,
  localparam int OP_W    = LANE_CNT * QW
) (
  input  logic            clk,
  input  mulStrobes_t     strobes,
  input  logic [OP_W-1:0] dstOp,
  input  logic [OP_W-1:0] srcOp,
  output logic [OP_W-1:0] result
);

  localparam int HALF  = ELEM_W / 2;
  localparam int EXTRA = LATENCY - MIN_LATENCY;

  logic [OP_W-1:0]   sumFlat;
  logic [2*OP_W-1:0] unusedOdd;

  for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
    logic [ELEM_W-1:0] capA, capB;
    logic [ELEM_W-1:0] ppLL, ppLH, ppHL, ppHH;
    logic [ELEM_W:0]   midSum;
    logic [QW-1:0]     laneProd;
    logic [QW-1:0]     laneSum;
    logic              laneOn;

    // Odd doublewords are never consumed
    assign unusedOdd[2*g*ELEM_W +: ELEM_W]     = dstOp[g*QW+ELEM_W +: ELEM_W];
    assign unusedOdd[(2*g+1)*ELEM_W +: ELEM_W] = srcOp[g*QW+ELEM_W +: ELEM_W];

    // Stage 1: capture the even element of this lane
    always_ff @(posedge clk) begin
      if (strobes.capEn) begin
        capA <= dstOp[g*QW +: ELEM_W];
        capB <= srcOp[g*QW +: ELEM_W];
      end
    end

    // Stage 2: four half-width partial products
    always_ff @(posedge clk) begin
      if (strobes.ppEn) begin
        ppLL <= {{HALF{1'b0}}, capA[HALF-1:0]}      * {{HALF{1'b0}}, capB[HALF-1:0]};
        ppLH <= {{HALF{1'b0}}, capA[HALF-1:0]}      * {{HALF{1'b0}}, capB[ELEM_W-1:HALF]};
        ppHL <= {{HALF{1'b0}}, capA[ELEM_W-1:HALF]} * {{HALF{1'b0}}, capB[HALF-1:0]};
        ppHH <= {{HALF{1'b0}}, capA[ELEM_W-1:HALF]} * {{HALF{1'b0}}, capB[ELEM_W-1:HALF]};
      end
    end

    // Stage 3: merge partial products, keep the low QW bits
    assign midSum   = {1'b0, ppLH} + {1'b0, ppHL};
    assign laneProd = {ppHH, ppLL} + ({{(QW-ELEM_W-1){1'b0}}, midSum} << HALF);

    if (g == 0) begin : g_base
      assign laneOn = 1'b1;
    end else begin : g_upper
      assign laneOn = strobes.wideAtSum;
    end

    always_ff @(posedge clk) begin
      if (strobes.sumEn) laneSum <= laneOn ? laneProd : '0;
    end

    assign sumFlat[g*QW +: QW] = laneSum;
  end

  // Balance stages up to the configured latency
  if (EXTRA == 0) begin : g_noDelay
    assign result = sumFlat;
  end else begin : g_delay
    logic [OP_W-1:0] dly [EXTRA];
    always_ff @(posedge clk) begin
      dly[0] <= sumFlat;
      for (int i = 1; i < EXTRA; i++) dly[i] <= dly[i-1];
    end
    assign result = dly[EXTRA-1];
  end

endmodule

// File: rtl/evenLaneMul.sv
module evenLaneMul
  import evenMulPkg::*;
#(
  parameter int ELEM_W   = 32,
  parameter int LANE_CNT = 2,
  parameter int LATENCY  = 6,
  localparam int OP_W    = LANE_CNT * 2 * ELEM_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic            inWide,
  input  logic [OP_W-1:0] dstOp,
  input  logic [OP_W-1:0] srcOp,
  output logic            outValid,
  output logic [OP_W-1:0] outResult
);

  mulStrobes_t strobes;

  evenMulCtrl #(
    .LATENCY(LATENCY)
  ) ctrlInst (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inWide  (inWide),
    .strobes (strobes),
    .outValid(outValid)
  );

  evenMulDatapath #(
    .ELEM_W  (ELEM_W),
    .LANE_CNT(LANE_CNT),
    .LATENCY (LATENCY)
  ) dpInst (
    .clk    (clk),
    .strobes(strobes),
    .dstOp  (dstOp),
    .srcOp  (srcOp),
    .result (outResult)
  );

endmodule

// File: rtl/evenLaneMulChk.sv
module evenLaneMulChk #(
  parameter int ELEM_W   = 32,
  parameter int LANE_CNT = 2,
  parameter int LATENCY  = 6,
  localparam int QW      = 2 * ELEM_W,
  localparam int OP_W    = LANE_CNT * QW
) (
  input logic            clk,
  input logic            rst,
  input logic            inValid,
  input logic            inWide,
  input logic [OP_W-1:0] dstOp,
  input logic [OP_W-1:0] srcOp,
  input logic            outValid,
  input logic [OP_W-1:0] outResult
);

  logic [OP_W-1:0] shadowRes  [LATENCY];
  logic            shadowVld  [LATENCY];
  logic            shadowWide [LATENCY];
  logic [OP_W-1:0] directRes;
  logic [2*OP_W-1:0] unusedChk;

  assign unusedChk = {dstOp, srcOp};

  // Direct full-width product for each lane
  always_comb begin
    directRes = '0;
    for (int g = 0; g < LANE_CNT; g++) begin
      if (g == 0 || inWide) begin
        directRes[g*QW +: QW] = {{ELEM_W{1'b0}}, dstOp[g*QW +: ELEM_W]}
                              * {{ELEM_W{1'b0}}, srcOp[g*QW +: ELEM_W]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LATENCY; i++) shadowVld[i] <= 1'b0;
    end else begin
      shadowVld[0] <= inValid;
      for (int i = 1; i < LATENCY; i++) shadowVld[i] <= shadowVld[i-1];
    end
  end

  always_ff @(posedge clk) begin
    shadowRes[0]  <= directRes;
    shadowWide[0] <= inWide;
    for (int i = 1; i < LATENCY; i++) begin
      shadowRes[i]  <= shadowRes[i-1];
      shadowWide[i] <= shadowWide[i-1];
    end
  end

  // R8
  reset_clears_chk: assert property (@(posedge clk) rst |=> !outValid);

  // R6
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    outValid == shadowVld[LATENCY-1]);

  // R1 R2
  lane_product_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outResult == shadowRes[LATENCY-1]);

  // R3
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !shadowWide[LATENCY-1]) |-> outResult[OP_W-1:QW] == '0);

endmodule

bind evenLaneMul evenLaneMulChk #(
  .ELEM_W  (ELEM_W),
  .LANE_CNT(LANE_CNT),
  .LATENCY (LATENCY)
) chkInst (.*);

// File: tb/evenLaneMul_test.sv
`timescale 1ns/1ps
module evenLaneMul_test;

  localparam int LAT  = 6;
  localparam int OPW  = 128;
  localparam int RING = 256;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           inValid = 1'b0;
  logic           inWide = 1'b0;
  logic [OPW-1:0] dstOp = '0;
  logic [OPW-1:0] srcOp = '0;
  logic           outValid;
  logic [OPW-1:0] outResult;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic           expVld [RING];
  logic [OPW-1:0] expRes [RING];
  string          expTag [RING];

  evenLaneMul uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inWide(inWide),
    .dstOp(dstOp), .srcOp(srcOp), .outValid(outValid), .outResult(outResult)
  );

  always #2 clk = ~clk;

  function automatic logic [OPW-1:0] model(input logic w, input logic [OPW-1:0] d, input logic [OPW-1:0] s);
    logic [63:0] lo, hi;
    lo = {32'd0, d[31:0]} * {32'd0, s[31:0]};
    hi = w ? ({32'd0, d[95:64]} * {32'd0, s[95:64]}) : 64'd0;
    return {hi, lo};
  endfunction

  // One cycle: check the output due now, then present the next input
  task automatic step(input logic v, input logic w, input logic [OPW-1:0] d,
                      input logic [OPW-1:0] s, input string tag, input logic r = 1'b0);
    int idx;
    @(negedge clk);
    idx = (cyc - LAT) & (RING - 1);
    checks++;
    if (outValid !== expVld[idx]) begin
      errors++;
      $display("FAIL %s valid cycle %0d: got %b expected %b", expTag[idx], cyc, outValid, expVld[idx]);
    end
    if (expVld[idx]) begin
      checks++;
      if (outResult !== expRes[idx]) begin
        errors++;
        $display("FAIL %s result cycle %0d: got %h expected %h", expTag[idx], cyc, outResult, expRes[idx]);
      end
    end
    rst = r; inValid = v; inWide = w; dstOp = d; srcOp = s;
    idx = cyc & (RING - 1);
    expVld[idx] = v && !r;
    expRes[idx] = model(w, d, s);
    expTag[idx] = (v && !r) ? tag : (r ? "R8" : "R6");
    if (r) begin
      for (int k = 1; k < LAT; k++) begin
        expVld[(cyc - k) & (RING - 1)] = 1'b0;
        expTag[(cyc - k) & (RING - 1)] = "R8";
      end
    end
    cyc++;
  endtask

  function automatic logic [OPW-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [OPW-1:0] d, s;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < RING; i++) begin
      expVld[i] = 1'b0; expRes[i] = '0; expTag[i] = "R6";
    end
    // Reset state (R8)
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (outValid !== 1'b0) begin
        errors++;
        $display("FAIL R8 reset: got outValid %b expected 0", outValid);
      end
    end
    // Directed corners
    step(1, 0, '0, '0, "R1");
    step(1, 1, '0, '0, "R2");
    step(1, 1, {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}}, "R5");
    step(1, 0, {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}}, "R3");
    step(1, 1, {32'h0, 32'h8000_0000, 32'h0, 32'h8000_0000},
               {32'h0, 32'd2, 32'h0, 32'd2}, "R5");
    step(1, 1, {32'hDEAD_BEEF, 32'd0, 32'hCAFE_F00D, 32'd0},
               {32'h1234_5678, 32'd0, 32'h9ABC_DEF0, 32'd0}, "R4");
    step(1, 1, {32'h0, 32'd7, 32'h0, 32'd3}, {32'h0, 32'd11, 32'h0, 32'd5}, "R2");
    step(1, 0, {32'h0, 32'd7, 32'h0, 32'd3}, {32'h0, 32'd11, 32'h0, 32'd5}, "R3");
    step(1, 1, {32'hFFFF_FFFF, 32'h0001_0000, 32'h5555_5555, 32'hFFFF_0000},
               {32'hAAAA_AAAA, 32'h0001_0000, 32'hFFFF_FFFF, 32'h0000_FFFF}, "R1");
    // Idle gap: valid must stay low (R6)
    repeat (LAT + 2) step(0, 0, rnd128(), rnd128(), "R6");
    // Random stream, odd lanes always random (R4, R7)
    for (int n = 0; n < 400; n++) begin
      d = rnd128(); s = rnd128();
      step(($urandom % 4) != 0, $urandom % 2, d, s, (n % 2) ? "R7" : "R4");
    end
    // Reset in flight, with a new operation in the same cycle (R8)
    for (int n = 0; n < LAT - 1; n++) step(1, n % 2, rnd128(), rnd128(), "R8");
    step(1, 1, rnd128(), rnd128(), "R8", 1'b1);
    repeat (LAT + 2) step(0, 0, '0, '0, "R8");
    for (int n = 0; n < 20; n++) step(1, n % 2, rnd128(), rnd128(), "R7");
    repeat (LAT + 2) step(0, 0, '0, '0, "R6");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule